// File: doc/BRIEF.md
# Frequency-Domain 2D Correlation Sequencer

This block computes the circular cross-correlation of a small square image against a fixed template. It works in the frequency domain and needs only three storage pairs. Two working pairs hold real and imaginary words and take turns as source and destination. The third pair holds the template spectrum, which is stored conjugated. The block does no transform arithmetic itself. It streams one line of N complex samples at a time to an external 1D transform engine over a valid/ready interface. It sets a mode line that selects the forward or inverse transform, and it takes the N results back over a second valid/ready interface.

The template spectrum is written once through its own port, and the block negates the imaginary part as it stores it. A one-cycle `start` in idle opens a frame. The frame then runs these steps in order:

1. N·N pixels are loaded.
2. Row transform.
3. Column transform.
4. In-place complex multiply against the template.
5. Inverse row transform.
6. Inverse column transform, scaled by 1/(N·N).

The correlation surface ends up in working memory 1. A host reads it through a registered read port after `done` pulses, and the largest value marks the match position.

Top module: `spec_corr_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pixReady`, `xfOutValid` and `xfInReady` are all 0.
- R2: A template write at address a stores (re, −im) at a, where the address is row·N + column. The stored spectrum stays in place over any number of later frames.
- R3: `start` is taken only while idle. `pixReady` is 1 from the cycle after `start` until N·N pixels have been accepted in row-major order. Each pixel, zero-extended, goes to the real bank of memory 1, and the matching imaginary word is cleared. A `start` pulse while busy has no effect.
- R4: Each frame runs exactly four transform passes of N·N samples each. The first two have `xfInverse` = 0 and the last two have `xfInverse` = 1, and no forward sample follows an inverse one. Row passes stream addresses line·N + k. Column passes stream addresses k·N + line.
- R5: A sample moves only in a cycle where valid and ready are both 1. While `xfOutValid` is held without `xfOutReady`, the sample and mode stay stable. A pass ends only after its N·N-th result has been accepted.
- R6: The multiply step forms (ar·br − ai·bi, ar·bi + ai·br). It rounds half-up by `PROD_SHIFT` bits and saturates to the W-bit signed range.
- R7: Results of the inverse column pass are divided by N·N, which is an arithmetic right shift by 2·log2(N) with round half-up, before they are stored.
- R8: After `done`, reading address a·N + b returns the circular correlation Σ t[r][s]·img[(r+a) mod N][(s+b) mod N] on `resRe`, and 0 on `resIm` for real inputs. Read data appears one cycle after the address.
- R9: `done` is a one-cycle pulse in the cycle after the last inverse result is accepted. In the following cycle the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a frame when idle |
| pixValid | input | 1 | Pixel presented |
| pixData | input | PW | Unsigned pixel |
| pixReady | output | 1 | Pixel accepted this cycle when valid |
| tmplWe | input | 1 | Template spectrum write |
| tmplAddr | input | 2·log2(N) | Template word address |
| tmplRe | input | W | Template spectrum real part |
| tmplIm | input | W | Template spectrum imaginary part (stored negated) |
| xfOutValid | output | 1 | Sample to the transform engine valid |
| xfOutReady | input | 1 | Transform engine takes the sample |
| xfOutRe | output | W | Sample real part |
| xfOutIm | output | W | Sample imaginary part |
| xfInverse | output | 1 | 1 selects the inverse transform |
| xfInValid | input | 1 | Transform result valid |
| xfInReady | output | 1 | Block takes the result |
| xfInRe | input | W | Result real part |
| xfInIm | input | W | Result imaginary part |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| resAddr | input | 2·log2(N) | Result read address |
| resRe | output | W | Result real part, one cycle after address |
| resIm | output | W | Result imaginary part, one cycle after address |

## Verification
`pixReady` is due one cycle after `start`. The pixels then take exactly one cycle each, and `pixReady` falls in the cycle after the last one. The bench samples every one of these on the falling edge that follows the rising edge at which the state changes. `done` is due in the cycle after the final inverse result is taken, and the bench sees it at the first falling edge where it is high, then expects `done` and `busy` both low one edge later. Result words are read by setting `resAddr` at a falling edge and comparing one full cycle later, which matches the single output register. The bench's transform engine counts forward and inverse samples to check pass order. It inserts stalls on both handshakes so that stable-while-stalled and valid-and-ready transfer rules are exercised.

// File: rtl/spec_corr_pkg.sv
`timescale 1ns/1ps
package spec_corr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_ROW_FWD, ST_COL_FWD, ST_MULT, ST_ROW_INV, ST_COL_INV, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    WS_PIX, WS_XF, WS_PROD
  } wr_src_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    rdFromM2;
    logic    wrM1;
    logic    wrM2;
    wr_src_e wrSrc;
    logic    scaleEn;
  } dp_ctrl_t;

endpackage

// File: rtl/spec_corr_ctrl.sv
`timescale 1ns/1ps
module spec_corr_ctrl
  import spec_corr_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      pixValid,
  output logic                      pixReady,
  output logic                      xfOutValid,
  input  logic                      xfOutReady,
  output logic                      xfInverse,
  input  logic                      xfInValid,
  output logic                      xfInReady,
  output logic                      busy,
  output logic                      done,
  output logic [2*$clog2(N)-1:0]    rdAddr,
  output logic [2*$clog2(N)-1:0]    wrAddr,
  output dp_ctrl_t                  ctl
);
  localparam int LG = $clog2(N);
  localparam int AW = 2 * LG;
  localparam int NN = N * N;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] LAST = CW'(NN - 1);

  seq_state_e state;
  logic [CW-1:0] sendCnt, recvCnt, stepCnt;
  logic inPass, colPass, outXfer, inXfer;

  // row order: line*N+k ; column order (stride N): k*N+line
  function automatic logic [AW-1:0] elemAddr(input logic [CW-1:0] e, input logic col);
    logic [AW-1:0] lin;
    lin = e[AW-1:0];
    return col ? {lin[LG-1:0], lin[AW-1:LG]} : lin;
  endfunction

  always_comb begin
    inPass  = (state == ST_ROW_FWD) || (state == ST_COL_FWD) ||
              (state == ST_ROW_INV) || (state == ST_COL_INV);
    colPass = (state == ST_COL_FWD) || (state == ST_COL_INV);
    xfOutValid = inPass && (sendCnt < CW'(NN));
    xfInReady  = inPass && (recvCnt < CW'(NN));
    outXfer    = xfOutValid && xfOutReady;
    inXfer     = xfInValid && xfInReady;
    xfInverse  = (state == ST_ROW_INV) || (state == ST_COL_INV);
    pixReady   = (state == ST_LOAD);
    busy       = (state != ST_IDLE);
    done       = (state == ST_DONE);
  end

  always_comb begin
    rdAddr = '0;
    wrAddr = '0;
    ctl    = '{rdFromM2: 1'b0, wrM1: 1'b0, wrM2: 1'b0, wrSrc: WS_XF, scaleEn: 1'b0};
    unique case (state)
      ST_LOAD: begin
        wrAddr    = stepCnt[AW-1:0];
        ctl.wrM1  = pixValid;
        ctl.wrSrc = WS_PIX;
      end
      ST_MULT: begin
        rdAddr    = stepCnt[AW-1:0];
        wrAddr    = stepCnt[AW-1:0];
        ctl.wrM1  = 1'b1;
        ctl.wrSrc = WS_PROD;
      end
      ST_ROW_FWD, ST_ROW_INV, ST_COL_FWD, ST_COL_INV: begin
        rdAddr       = elemAddr(sendCnt, colPass);
        wrAddr       = elemAddr(recvCnt, colPass);
        ctl.rdFromM2 = colPass;
        ctl.wrM1     = colPass && inXfer;
        ctl.wrM2     = !colPass && inXfer;
        ctl.scaleEn  = (state == ST_COL_INV);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sendCnt <= '0;
      recvCnt <= '0;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_LOAD;
          stepCnt <= '0;
        end
        ST_LOAD: if (pixValid) begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST) begin
            state   <= ST_ROW_FWD;
            stepCnt <= '0;
            sendCnt <= '0;
            recvCnt <= '0;
          end
        end
        ST_MULT: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST) begin
            state   <= ST_ROW_INV;
            stepCnt <= '0;
          end
        end
        ST_ROW_FWD, ST_COL_FWD, ST_ROW_INV, ST_COL_INV: begin
          if (outXfer) sendCnt <= sendCnt + 1'b1;
          if (inXfer) begin
            recvCnt <= recvCnt + 1'b1;
            if (recvCnt == LAST) begin
              sendCnt <= '0;
              recvCnt <= '0;
              unique case (state)
                ST_ROW_FWD: state <= ST_COL_FWD;
                ST_COL_FWD: state <= ST_MULT;
                ST_ROW_INV: state <= ST_COL_INV;
                default:    state <= ST_DONE;
              endcase
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: LOAD is entered only from idle, so start while busy cannot restart a frame
  a_r3_load_only_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && state != ST_LOAD) |=> (state != ST_LOAD));

  // R5: a pass never sees more results than it sent samples
  a_r5_recv_after_send: assert property (@(posedge clk) disable iff (!rstN)
    inPass |-> (recvCnt <= sendCnt));

endmodule

// File: rtl/spec_corr_dp.sv
`timescale 1ns/1ps
module spec_corr_dp
  import spec_corr_pkg::*;
#(
  parameter int N          = 4,
  parameter int W          = 24,
  parameter int PW         = 8,
  parameter int PROD_SHIFT = 0
) (
  input  logic                   clk,
  input  dp_ctrl_t               ctl,
  input  logic [2*$clog2(N)-1:0] rdAddr,
  input  logic [2*$clog2(N)-1:0] wrAddr,
  input  logic [PW-1:0]          pixData,
  input  logic                   tmplWe,
  input  logic [2*$clog2(N)-1:0] tmplAddr,
  input  logic signed [W-1:0]    tmplRe,
  input  logic signed [W-1:0]    tmplIm,
  output logic signed [W-1:0]    srcRe,
  output logic signed [W-1:0]    srcIm,
  input  logic signed [W-1:0]    xfInRe,
  input  logic signed [W-1:0]    xfInIm,
  input  logic [2*$clog2(N)-1:0] resAddr,
  output logic signed [W-1:0]    resRe,
  output logic signed [W-1:0]    resIm
);
  localparam int LG   = $clog2(N);
  localparam int NN   = N * N;
  localparam int SH   = 2 * LG;
  localparam int PWID = 2 * W + 2;
  localparam int RNDV = (1 << PROD_SHIFT) >> 1;
  localparam logic signed [PWID-1:0] MAXP = {{(PWID-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PWID-1:0] MINP = {{(PWID-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [W-1:0]    MAXW = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]    MINW = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] m1Re [NN];
  logic signed [W-1:0] m1Im [NN];
  logic signed [W-1:0] m2Re [NN];
  logic signed [W-1:0] m2Im [NN];
  logic signed [W-1:0] tRe  [NN];
  logic signed [W-1:0] tIm  [NN];

  logic signed [W-1:0] prodRe, prodIm, sclRe, sclIm, wrRe, wrIm;

  function automatic logic signed [W-1:0] fitWord(input logic signed [PWID-1:0] v);
    logic signed [PWID-1:0] s;
    s = (v + PWID'(RNDV)) >>> PROD_SHIFT;
    if (s > MAXP)      return MAXW;
    else if (s < MINP) return MINW;
    else               return s[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] scaleDown(input logic signed [W-1:0] v);
    logic signed [W:0] e;
    e = $signed({v[W-1], v});
    e = (e + (W+1)'(1 << (SH - 1))) >>> SH;
    return e[W-1:0];
  endfunction

  always_comb begin
    srcRe = ctl.rdFromM2 ? m2Re[rdAddr] : m1Re[rdAddr];
    srcIm = ctl.rdFromM2 ? m2Im[rdAddr] : m1Im[rdAddr];
  end

  // complex multiply against the stored conjugated template
  always_comb begin
    logic signed [PWID-1:0] ar, ai, br, bi;
    ar = PWID'(m1Re[rdAddr]);
    ai = PWID'(m1Im[rdAddr]);
    br = PWID'(tRe[rdAddr]);
    bi = PWID'(tIm[rdAddr]);
    prodRe = fitWord(ar * br - ai * bi);
    prodIm = fitWord(ar * bi + ai * br);
  end

  always_comb begin
    sclRe = scaleDown(xfInRe);
    sclIm = scaleDown(xfInIm);
    unique case (ctl.wrSrc)
      WS_PIX:  begin wrRe = W'($unsigned(pixData)); wrIm = '0; end
      WS_PROD: begin wrRe = prodRe; wrIm = prodIm; end
      default: begin
        wrRe = ctl.scaleEn ? sclRe : xfInRe;
        wrIm = ctl.scaleEn ? sclIm : xfInIm;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (ctl.wrM1) begin
      m1Re[wrAddr] <= wrRe;
      m1Im[wrAddr] <= wrIm;
    end
    if (ctl.wrM2) begin
      m2Re[wrAddr] <= wrRe;
      m2Im[wrAddr] <= wrIm;
    end
    if (tmplWe) begin
      tRe[tmplAddr] <= tmplRe;
      tIm[tmplAddr] <= (tmplIm == MINW) ? MAXW : -tmplIm;
    end
    resRe <= m1Re[resAddr];
    resIm <= m1Im[resAddr];
  end

  // R6: a product write never lands while a transform result is being stored
  a_r6_prod_exclusive: assert property (@(posedge clk)
    (ctl.wrSrc == WS_PROD) |-> !ctl.wrM2 && !ctl.scaleEn);

endmodule

// File: rtl/spec_corr_seq.sv
`timescale 1ns/1ps
module spec_corr_seq
  import spec_corr_pkg::*;
#(
  parameter int N          = 4,
  parameter int W          = 24,
  parameter int PW         = 8,
  parameter int PROD_SHIFT = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   pixValid,
  input  logic [PW-1:0]          pixData,
  output logic                   pixReady,
  input  logic                   tmplWe,
  input  logic [2*$clog2(N)-1:0] tmplAddr,
  input  logic signed [W-1:0]    tmplRe,
  input  logic signed [W-1:0]    tmplIm,
  output logic                   xfOutValid,
  input  logic                   xfOutReady,
  output logic signed [W-1:0]    xfOutRe,
  output logic signed [W-1:0]    xfOutIm,
  output logic                   xfInverse,
  input  logic                   xfInValid,
  output logic                   xfInReady,
  input  logic signed [W-1:0]    xfInRe,
  input  logic signed [W-1:0]    xfInIm,
  output logic                   busy,
  output logic                   done,
  input  logic [2*$clog2(N)-1:0] resAddr,
  output logic signed [W-1:0]    resRe,
  output logic signed [W-1:0]    resIm
);
  localparam int AW = 2 * $clog2(N);

  dp_ctrl_t ctl;
  logic [AW-1:0] rdAddr, wrAddr;

  spec_corr_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pixValid(pixValid), .pixReady(pixReady),
    .xfOutValid(xfOutValid), .xfOutReady(xfOutReady), .xfInverse(xfInverse),
    .xfInValid(xfInValid), .xfInReady(xfInReady), .busy(busy), .done(done),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .ctl(ctl)
  );

  spec_corr_dp #(.N(N), .W(W), .PW(PW), .PROD_SHIFT(PROD_SHIFT)) u_dp (
    .clk(clk), .ctl(ctl), .rdAddr(rdAddr), .wrAddr(wrAddr), .pixData(pixData),
    .tmplWe(tmplWe), .tmplAddr(tmplAddr), .tmplRe(tmplRe), .tmplIm(tmplIm),
    .srcRe(xfOutRe), .srcIm(xfOutIm), .xfInRe(xfInRe), .xfInIm(xfInIm),
    .resAddr(resAddr), .resRe(resRe), .resIm(resIm)
  );

  // R5: a stalled sample and its mode stay put until taken
  a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (xfOutValid && !xfOutReady) |=> xfOutValid && $stable(xfOutRe) &&
                                     $stable(xfOutIm) && $stable(xfInverse));

  // R9: done is a single-cycle pulse followed by idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  // R3: pixels are only requested inside a frame
  a_r3_ready_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    pixReady |-> busy && !done && !xfOutValid);

endmodule

// File: tb/spec_corr_seq_bench.sv
`timescale 1ns/1ps
module spec_corr_seq_bench;
  localparam int N  = 4;
  localparam int W  = 24;
  localparam int PW = 8;
  localparam int NN = N * N;
  localparam int AW = 4;

  logic clk = 0, rstN = 0, start = 0, pixValid = 0, tmplWe = 0;
  logic [PW-1:0] pixData = 0;
  logic [AW-1:0] tmplAddr = 0, resAddr = 0;
  logic signed [W-1:0] tmplRe = 0, tmplIm = 0, xfInRe = 0, xfInIm = 0;
  logic xfOutReady = 0, xfInValid = 0;
  logic pixReady, xfOutValid, xfInverse, xfInReady, busy, done;
  logic signed [W-1:0] xfOutRe, xfOutIm, resRe, resIm;

  always #2.5 clk = ~clk;

  spec_corr_seq #(.N(N), .W(W), .PW(PW), .PROD_SHIFT(0)) u_spec_corr_seq (
    .clk(clk), .rstN(rstN), .start(start), .pixValid(pixValid), .pixData(pixData),
    .pixReady(pixReady), .tmplWe(tmplWe), .tmplAddr(tmplAddr), .tmplRe(tmplRe),
    .tmplIm(tmplIm), .xfOutValid(xfOutValid), .xfOutReady(xfOutReady),
    .xfOutRe(xfOutRe), .xfOutIm(xfOutIm), .xfInverse(xfInverse),
    .xfInValid(xfInValid), .xfInReady(xfInReady), .xfInRe(xfInRe), .xfInIm(xfInIm),
    .busy(busy), .done(done), .resAddr(resAddr), .resRe(resRe), .resIm(resIm)
  );

  int nChecks = 0, nFail = 0;
  longint img [NN], tpl [NN], expc [NN], specR [NN], specI [NN];

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // N-point DFT with twiddles that are powers of j (N = 4)
  task automatic dftLine(input longint ir[N], input longint ii[N], input bit inv,
                         output longint orr[N], output longint oi[N]);
    for (int k = 0; k < N; k++) begin
      longint sr = 0, si = 0;
      for (int n = 0; n < N; n++) begin
        int p = inv ? (n * k) % 4 : (3 * n * k) % 4;
        case (p)
          0: begin sr += ir[n]; si += ii[n]; end
          1: begin sr -= ii[n]; si += ir[n]; end
          2: begin sr -= ir[n]; si -= ii[n]; end
          default: begin sr += ii[n]; si -= ir[n]; end
        endcase
      end
      orr[k] = sr; oi[k] = si;
    end
  endtask

  // transform-engine model
  bit stallOn = 0;
  int engTick = 0, fwdSeen = 0, invSeen = 0;
  bit orderBad = 0;
  initial begin
    longint eiR[N], eiI[N], eoR[N], eoI[N];
    bit collecting = 1, mode = 0;
    int cnt = 0;
    forever begin
      @(negedge clk);
      engTick++;
      if (collecting) begin
        xfInValid = 0;
        xfOutReady = !(stallOn && (engTick % 3 == 0));
        #1;
        if (xfOutValid && xfOutReady) begin
          eiR[cnt] = xfOutRe; eiI[cnt] = xfOutIm; mode = xfInverse;
          if (xfInverse) invSeen++;
          else begin fwdSeen++; if (invSeen != 0) orderBad = 1; end
          cnt++;
          if (cnt == N) begin
            dftLine(eiR, eiI, mode, eoR, eoI);
            collecting = 0; cnt = 0;
          end
        end
      end else begin
        xfOutReady = 0;
        xfInValid = !(stallOn && (engTick % 4 == 1));
        xfInRe = W'(eoR[cnt]); xfInIm = W'(eoI[cnt]);
        #1;
        if (xfInValid && xfInReady) begin
          cnt++;
          if (cnt == N) begin collecting = 1; cnt = 0; end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  task automatic calcSpectrum();
    longint ar[N], ai[N], br[N], bi[N];
    for (int k = 0; k < NN; k++) begin specR[k] = tpl[k]; specI[k] = 0; end
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin ar[c] = specR[r*N+c]; ai[c] = specI[r*N+c]; end
      dftLine(ar, ai, 0, br, bi);
      for (int c = 0; c < N; c++) begin specR[r*N+c] = br[c]; specI[r*N+c] = bi[c]; end
    end
    for (int c = 0; c < N; c++) begin
      for (int r = 0; r < N; r++) begin ar[r] = specR[r*N+c]; ai[r] = specI[r*N+c]; end
      dftLine(ar, ai, 0, br, bi);
      for (int r = 0; r < N; r++) begin specR[r*N+c] = br[r]; specI[r*N+c] = bi[r]; end
    end
  endtask

  task automatic writeTemplate();
    for (int k = 0; k < NN; k++) begin
      @(negedge clk);
      tmplWe = 1; tmplAddr = AW'(k); tmplRe = W'(specR[k]); tmplIm = W'(specI[k]);
    end
    @(negedge clk);
    tmplWe = 0;
  endtask

  task automatic calcCorr();
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) begin
        longint s = 0;
        for (int r = 0; r < N; r++)
          for (int c = 0; c < N; c++)
            s += tpl[r*N+c] * img[((r+a)%N)*N + (c+b)%N];
        expc[a*N+b] = s;
      end
  endtask

  task automatic runFrame(input bit pokeStart, input bit realOut);
    int waitCnt = 0;
    fwdSeen = 0; invSeen = 0; orderBad = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(pixReady == 1, "R3 pixReady after start", pixReady, 1);
    for (int k = 0; k < NN; k++) begin
      pixValid = 1; pixData = PW'(img[k]);
      @(negedge clk);
    end
    pixValid = 0;
    check(pixReady == 0, "R3 pixReady drops after last pixel", pixReady, 0);
    if (pokeStart) begin
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
      check(pixReady == 0, "R3 start while busy ignored", pixReady, 0);
      @(negedge clk);
      check(pixReady == 0 && busy == 1, "R3 still in passes", pixReady, 0);
    end
    while (!done && waitCnt < 5000) begin @(negedge clk); waitCnt++; end
    check(done == 1, "R9 done raised", done, 1);
    @(negedge clk);
    check(done == 0 && busy == 0, "R9 done single pulse then idle", {done, busy}, 0);
    check(fwdSeen == 2*NN, "R4 forward sample count", fwdSeen, 2*NN);
    check(invSeen == 2*NN, "R4 inverse sample count", invSeen, 2*NN);
    check(orderBad == 0, "R4 forward before inverse", orderBad, 0);
    for (int k = 0; k < NN; k++) begin
      resAddr = AW'(k);
      @(negedge clk);
      check(longint'(resRe) == expc[k], "R8 correlation real", resRe, expc[k]);
      if (realOut) check(resIm == 0, "R8 correlation imag", resIm, 0);
    end
  endtask

  task automatic testReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !pixReady && !xfOutValid && !xfInReady, "R1 reset outputs",
          {busy, done, pixReady, xfOutValid, xfInReady}, 0);
    rstN = 1;
    @(negedge clk);
    check(!busy, "R1 idle after reset", busy, 0);
  endtask

  task automatic testBasic();
    for (int k = 0; k < NN; k++) begin img[k] = (k * 7 + 3) % 16; tpl[k] = 0; end
    tpl[0] = 1; tpl[1] = 2; tpl[4] = 3; tpl[9] = 1;
    calcSpectrum(); writeTemplate(); calcCorr();
    stallOn = 0;
    runFrame(0, 1); // R2 R4 R7 R8 basic frame, row/column addressing
  endtask

  task automatic testPersist();
    for (int k = 0; k < NN; k++) img[k] = (k * k + 5) % 13;
    calcCorr();
    stallOn = 1;
    runFrame(0, 1); // R2 template kept, R5 stalls on both sides
  endtask

  task automatic testStartIgnored();
    for (int k = 0; k < NN; k++) img[k] = 15 - k;
    calcCorr();
    stallOn = 1;
    runFrame(1, 1); // R3 start while busy has no effect on the result
  endtask

  task automatic testSaturate();
    longint maxW = (64'sd1 <<< (W - 1)) - 1;
    for (int k = 0; k < NN; k++) begin
      specR[k] = maxW; specI[k] = 0; img[k] = 10;
      expc[k] = (maxW + 8) >>> 4; // R6 saturated product, R7 rounded 1/16 scale
    end
    writeTemplate();
    stallOn = 0;
    runFrame(0, 1);
  endtask

  initial begin
    testReset();
    testBasic();
    testPersist();
    testStartIgnored();
    testSaturate();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule